// File: doc/BRIEF.md
# Endianness-Selectable Byte-Addressed Data Memory

This block is the data-side storage of a small load/store processor. It keeps its contents as 32-bit words but is addressed in bytes, and it carries out byte, halfword and word stores and loads. The address arriving here is already complete: the base-plus-offset sum is formed upstream. A static mode input chooses whether the lowest byte address of a word holds that word's most significant byte (big-endian) or its least significant byte (little-endian).

The block routes each sub-word access to the correct byte lanes of the stored word for the selected mode. Stores write only the lanes they address. Loads return the addressed bytes right-justified on the register-side bus, sign-extended or zero-extended as requested. The same stored word therefore reads back as different byte values at a given address once the mode changes.

Reads are registered. A load's data appears one clock after its strobe. An access that is not naturally aligned, or that uses the reserved size code, does not touch memory and raises an error flag.

Top module: `endian_data_mem`

## Requirements
- R1: After reset, `rdData` is 0 and `misalign` is 0.
- R2: With `bigEndian`=1, byte offset k (0..3) of a word maps to bits [8*(3-k)+7 : 8*(3-k)]. A word store of 0x12345678 to address 1000 then reads back as bytes 0x12, 0x34, 0x56, 0x78 at addresses 1000..1003. A word store of 5 to address 8 reads 0x00 at address 8 and 0x05 at address 11.
- R3: With `bigEndian`=0, byte offset k maps to bits [8*k+7 : 8*k]. The word 0x12345678 stored at address 1000 reads back as 0x78 at 1000 and 0x12 at 1003.
- R4: Halfword loads follow the same ordering. For the word 0x12345678 at address 1000, big-endian mode reads 0x1234 at 1000 and 0x5678 at 1002. Little-endian mode reads 0x5678 at 1000 and 0x1234 at 1002.
- R5: A byte store changes only its own lane, and a halfword store changes only its two lanes; the other bytes of the word keep their values. For example, a byte store of 5 to address 2 followed by a byte load from address 2 returns 0x05.
- R6: `accSize` encodes 00 as byte, 01 as halfword and 10 as word. Byte and halfword loads are sign-extended from their top bit when `signedLd`=1 and zero-extended when `signedLd`=0. Word loads return all 32 bits unchanged.
- R7: A halfword access at an odd address, a word access at an address that is not a multiple of 4, or any access with `accSize`=11 is misaligned. In the next cycle `misalign` is 1. A misaligned access writes nothing, and a misaligned load leaves `rdData` unchanged. `misalign` is 0 in the cycle after any cycle without a misaligned access.
- R8: Load data appears on `rdData` in the cycle after `loadEn`, and `rdData` holds its value in every cycle that follows a cycle without a valid load.
- R9: A load in the same cycle as a store to the same word returns the data as it is after that store. A load in the cycle right after a store also returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bigEndian | input | 1 | Static byte-order mode: 1 = big-endian, 0 = little-endian |
| addr | input | ADDR_W | Byte address of the access |
| wrData | input | 32 | Store data, right-justified |
| accSize | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| storeEn | input | 1 | Store strobe |
| loadEn | input | 1 | Load strobe |
| signedLd | input | 1 | 1 = sign-extend sub-word loads, 0 = zero-extend |
| rdData | output | 32 | Registered load result |
| misalign | output | 1 | Registered flag for a misaligned or reserved-size access |

## Verification
The functions that can meet in one cycle are a store and a load: both strobes can be high together, even on the same word with different lanes or sizes. The random phase draws the two strobes independently over a 32-byte window, so same-word collisions happen often in both modes. Directed cases add a full overlap and a load placed immediately after a store. Each result is compared with a byte-level reference model that applies the store first and then evaluates the load. Any stale-data read or lane error is therefore reported against R9 or R5.

// File: rtl/endian_mem_pkg.sv
package endian_mem_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W = 8 * WORD_BYTES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // decoded access, from control to datapath
  typedef struct packed {
    logic                  wrEn;
    logic                  rdEn;
    logic                  alignErr;
    logic [WORD_BYTES-1:0] byteEn;
    logic [1:0]            laneBase;
    accSize_e              extSize;
    logic                  signExt;
  } memStrobes_t;
endpackage

// File: rtl/endian_mem_ctrl.sv
module endian_mem_ctrl
  import endian_mem_pkg::*;
(
  input  logic        bigEndian,
  input  logic        storeEn,
  input  logic        loadEn,
  input  logic        signedLd,
  input  logic [1:0]  accSize,
  input  logic [1:0]  byteOffs,
  output memStrobes_t strobes
);
  logic                  bad;
  logic [1:0]            base;
  logic [WORD_BYTES-1:0] mask;
  accSize_e              sizeCode;

  assign sizeCode = accSize_e'(accSize);

  always_comb begin
    bad  = 1'b0;
    base = 2'd0;
    mask = '0;
    unique case (sizeCode)
      SZ_BYTE: begin
        base = bigEndian ? (2'd3 - byteOffs) : byteOffs;
        mask = 4'b0001 << base;
      end
      SZ_HALF: begin
        bad  = byteOffs[0];
        base = bigEndian ? (2'd2 - byteOffs) : byteOffs;
        mask = 4'b0011 << base;
      end
      SZ_WORD: begin
        bad  = (byteOffs != 2'd0);
        mask = 4'b1111;
      end
      default: bad = 1'b1;
    endcase
  end

  always_comb begin
    strobes.wrEn     = storeEn & ~bad;
    strobes.rdEn     = loadEn & ~bad;
    strobes.alignErr = (storeEn | loadEn) & bad;
    strobes.byteEn   = mask;
    strobes.laneBase = base;
    strobes.extSize  = sizeCode;
    strobes.signExt  = signedLd;
  end
endmodule

// File: rtl/endian_mem_dp.sv
module endian_mem_dp
  import endian_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-3:0]   wordIdx,
  input  logic [WORD_W-1:0]   wrData,
  input  memStrobes_t         strobes,
  output logic [WORD_W-1:0]   rdData,
  output logic                misalign
);
  localparam int DEPTH = 2 ** (ADDR_W - 2);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] wrShifted;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] readSel;
  logic [WORD_W-1:0] extended;

  assign wrShifted = wrData << {strobes.laneBase, 3'b000};

  // write-first merge: a load sees the store of the same cycle
  always_comb begin
    merged = mem[wordIdx];
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (strobes.wrEn && strobes.byteEn[b]) begin
        merged[8*b +: 8] = wrShifted[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.wrEn) mem[wordIdx] <= merged;
  end

  assign readSel = merged >> {strobes.laneBase, 3'b000};

  always_comb begin
    unique case (strobes.extSize)
      SZ_BYTE: extended = {{(WORD_W-8){strobes.signExt & readSel[7]}}, readSel[7:0]};
      SZ_HALF: extended = {{(WORD_W-16){strobes.signExt & readSel[15]}}, readSel[15:0]};
      default: extended = readSel;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData   <= '0;
      misalign <= 1'b0;
    end else begin
      misalign <= strobes.alignErr;
      if (strobes.rdEn) rdData <= extended;
    end
  end
endmodule

// File: rtl/endian_data_mem.sv
module endian_data_mem
  import endian_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bigEndian,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic [1:0]        accSize,
  input  logic              storeEn,
  input  logic              loadEn,
  input  logic              signedLd,
  output logic [31:0]       rdData,
  output logic              misalign
);
  memStrobes_t strobes;

  endian_mem_ctrl u_ctrl (
    .bigEndian(bigEndian),
    .storeEn  (storeEn),
    .loadEn   (loadEn),
    .signedLd (signedLd),
    .accSize  (accSize),
    .byteOffs (addr[1:0]),
    .strobes  (strobes)
  );

  endian_mem_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wordIdx (addr[ADDR_W-1:2]),
    .wrData  (wrData),
    .strobes (strobes),
    .rdData  (rdData),
    .misalign(misalign)
  );
endmodule

// File: rtl/endian_mem_checks.sv
module endian_mem_checks #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bigEndian,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [1:0]        accSize,
  input logic              storeEn,
  input logic              loadEn,
  input logic              signedLd,
  input logic [31:0]       rdData,
  input logic              misalign
);
  logic misAcc;
  assign misAcc = (accSize == 2'b11) || (accSize == 2'b01 && addr[0]) ||
                  (accSize == 2'b10 && addr[1:0] != 2'b00);

  assert_flag_on_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((storeEn || loadEn) && misAcc) |=> misalign);

  assert_flag_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !((storeEn || loadEn) && misAcc) |=> !misalign);

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(loadEn && !misAcc) |=> $stable(rdData));

  assert_byte_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loadEn && !signedLd && accSize == 2'b00) |=> (rdData[31:8] == 24'd0));

  assert_half_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loadEn && !signedLd && accSize == 2'b01 && !addr[0]) |=> (rdData[31:16] == 16'd0));

  assert_byte_sign_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loadEn && signedLd && accSize == 2'b00) |=> (rdData[31:8] == {24{rdData[7]}}));

  assert_half_sign_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loadEn && signedLd && accSize == 2'b01 && !addr[0]) |=> (rdData[31:16] == {16{rdData[15]}}));
endmodule

bind endian_data_mem endian_mem_checks #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_endian_data_mem.sv
module sim_endian_data_mem;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bigEndian = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wrData = '0;
  logic [1:0]        accSize = 2'b00;
  logic              storeEn = 1'b0;
  logic              loadEn = 1'b0;
  logic              signedLd = 1'b0;
  logic [31:0]       rdData;
  logic              misalign;

  int testCount = 0;
  int failCount = 0;
  logic [31:0] refMem [2**(ADDR_W-2)];
  logic [31:0] expRd = 32'd0;

  always #5 clk = ~clk;

  endian_data_mem #(.ADDR_W(ADDR_W)) u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // byte offset k -> bit lane per R2/R3
  function automatic int laneOf(input logic [1:0] k, input logic big);
    return big ? (3 - int'(k)) : int'(k);
  endfunction

  function automatic logic [7:0] getByte(input logic [ADDR_W-1:0] a, input logic big);
    return refMem[a[ADDR_W-1:2]][8*laneOf(a[1:0], big) +: 8];
  endfunction

  task automatic setByte(input logic [ADDR_W-1:0] a, input logic big, input logic [7:0] v);
    refMem[a[ADDR_W-1:2]][8*laneOf(a[1:0], big) +: 8] = v;
  endtask

  task automatic refStore(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic big, input logic [31:0] wd);
    case (sz)
      2'b00: setByte(a, big, wd[7:0]);
      2'b01: begin
        setByte(a,     big, big ? wd[15:8] : wd[7:0]);
        setByte(a + 1, big, big ? wd[7:0]  : wd[15:8]);
      end
      default: for (int i = 0; i < 4; i++)
        setByte(a + ADDR_W'(i), big, big ? wd[8*(3-i) +: 8] : wd[8*i +: 8]);
    endcase
  endtask

  function automatic logic [31:0] refLoad(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic big, input logic sg);
    logic [7:0] b0, b1, b2, b3;
    logic [15:0] h;
    b0 = getByte(a, big); b1 = getByte(a + 1, big);
    b2 = getByte(a + 2, big); b3 = getByte(a + 3, big);
    case (sz)
      2'b00: return {{24{sg & b0[7]}}, b0};
      2'b01: begin
        h = big ? {b0, b1} : {b1, b0};
        return {{16{sg & h[15]}}, h};
      end
      default: return big ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
    endcase
  endfunction

  // called at a negedge; ends at the next negedge with strobes released
  task automatic doOp(input logic st, input logic ld, input logic [ADDR_W-1:0] a,
                      input logic [1:0] sz, input logic sg, input logic [31:0] wd, input string req);
    logic bad;
    bad = (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
    storeEn = st; loadEn = ld; addr = a; accSize = sz; signedLd = sg; wrData = wd;
    @(negedge clk);
    storeEn = 1'b0; loadEn = 1'b0;
    if (st && !bad) refStore(a, sz, bigEndian, wd);
    if (ld && !bad) expRd = refLoad(a, sz, bigEndian, sg);
    check(rdData === expRd, {req, " rdData"}, rdData, expRd);
    check(misalign === ((st || ld) && bad), {req, " misalign"}, 32'(misalign), 32'((st || ld) && bad));
  endtask

  initial begin
    #(200000 * 10);
    failCount++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    check(rdData === 32'd0, "R1 reset rdData", rdData, 32'd0);
    check(misalign === 1'b0, "R1 reset misalign", 32'(misalign), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill the random window
    for (int w = 0; w < 8; w++) doOp(1, 0, ADDR_W'(4*w), 2'b10, 0, $urandom, "R5 init");

    // R2: big-endian byte order
    bigEndian = 1'b1; @(negedge clk);
    doOp(1, 0, 10'd1000, 2'b10, 0, 32'h12345678, "R2 store");
    doOp(0, 1, 10'd1000, 2'b00, 0, 0, "R2 byte@1000");
    check(rdData === 32'h12, "R2 literal 0x12", rdData, 32'h12);
    doOp(0, 1, 10'd1003, 2'b00, 0, 0, "R2 byte@1003");
    check(rdData === 32'h78, "R2 literal 0x78", rdData, 32'h78);
    doOp(0, 1, 10'd1000, 2'b01, 0, 0, "R4 BE half@1000");
    check(rdData === 32'h1234, "R4 literal BE 1000", rdData, 32'h1234);
    doOp(0, 1, 10'd1002, 2'b01, 0, 0, "R4 BE half@1002");
    check(rdData === 32'h5678, "R4 literal BE 1002", rdData, 32'h5678);
    doOp(1, 0, 10'd8, 2'b10, 0, 32'd5, "R2 word 5@8");
    doOp(0, 1, 10'd8, 2'b00, 0, 0, "R2 byte@8");
    check(rdData === 32'h00, "R2 literal byte@8", rdData, 32'h00);
    doOp(0, 1, 10'd11, 2'b00, 0, 0, "R2 byte@11");
    check(rdData === 32'h05, "R2 literal byte@11", rdData, 32'h05);

    // R3 / R4: same storage viewed little-endian
    bigEndian = 1'b0; @(negedge clk);
    doOp(0, 1, 10'd1000, 2'b00, 0, 0, "R3 byte@1000");
    check(rdData === 32'h78, "R3 literal 0x78", rdData, 32'h78);
    doOp(0, 1, 10'd1003, 2'b00, 0, 0, "R3 byte@1003");
    check(rdData === 32'h12, "R3 literal 0x12", rdData, 32'h12);
    doOp(0, 1, 10'd1000, 2'b01, 0, 0, "R4 LE half@1000");
    check(rdData === 32'h5678, "R4 literal LE 1000", rdData, 32'h5678);
    doOp(0, 1, 10'd1002, 2'b01, 0, 0, "R4 LE half@1002");
    check(rdData === 32'h1234, "R4 literal LE 1002", rdData, 32'h1234);

    // R5: lane isolation
    doOp(1, 0, 10'd2, 2'b00, 0, 32'd5, "R5 byte store");
    doOp(0, 1, 10'd2, 2'b00, 0, 0, "R5 byte load");
    check(rdData === 32'h05, "R5 literal 0x05", rdData, 32'h05);
    doOp(1, 0, 10'd12, 2'b10, 0, 32'hAABBCCDD, "R5 word");
    doOp(1, 0, 10'd13, 2'b00, 0, 32'h11, "R5 byte mid");
    doOp(0, 1, 10'd12, 2'b10, 0, 0, "R5 word after byte");
    check(rdData === 32'hAABB11DD, "R5 literal", rdData, 32'hAABB11DD);
    doOp(1, 0, 10'd14, 2'b01, 0, 32'h9922, "R5 half");
    doOp(0, 1, 10'd12, 2'b10, 0, 0, "R5 word after half");

    // R6: extension
    doOp(1, 0, 10'd20, 2'b00, 0, 32'h80, "R6 byte");
    doOp(0, 1, 10'd20, 2'b00, 1, 0, "R6 signed byte");
    check(rdData === 32'hFFFFFF80, "R6 literal sext", rdData, 32'hFFFFFF80);
    doOp(0, 1, 10'd20, 2'b00, 0, 0, "R6 unsigned byte");
    doOp(1, 0, 10'd22, 2'b01, 0, 32'h8001, "R6 half");
    doOp(0, 1, 10'd22, 2'b01, 1, 0, "R6 signed half");
    check(rdData === 32'hFFFF8001, "R6 literal half sext", rdData, 32'hFFFF8001);

    // R7: misalignment
    doOp(0, 1, 10'd16, 2'b10, 0, 0, "R7 before");
    doOp(1, 0, 10'd17, 2'b01, 0, 32'hFFFF, "R7 odd half store");
    doOp(0, 1, 10'd18, 2'b10, 0, 0, "R7 word@18 load");
    doOp(1, 1, 10'd16, 2'b11, 0, 32'hFFFFFFFF, "R7 reserved size");
    doOp(0, 1, 10'd16, 2'b10, 0, 0, "R7 unchanged");

    // R8: hold
    doOp(0, 0, 10'd0, 2'b10, 0, 0, "R8 idle hold");
    doOp(1, 0, 10'd4, 2'b10, 0, 32'h0BADF00D, "R8 store no load");

    // R9: store and load together, then back-to-back
    doOp(1, 1, 10'd24, 2'b10, 0, 32'hCAFE1234, "R9 same cycle");
    check(rdData === 32'hCAFE1234, "R9 literal", rdData, 32'hCAFE1234);
    doOp(1, 1, 10'd25, 2'b00, 0, 32'h77, "R9 same cycle byte");
    doOp(1, 0, 10'd28, 2'b01, 0, 32'h4455, "R9 store");
    doOp(0, 1, 10'd28, 2'b10, 0, 0, "R9 next cycle");

    // random mix of both modes
    for (int n = 0; n < 1500; n++) begin
      logic [1:0] sz;
      logic [ADDR_W-1:0] a;
      if (n % 100 == 0) begin bigEndian = $urandom % 2; @(negedge clk); end
      r = $urandom % 8;
      sz = (r < 3) ? 2'b00 : (r < 5) ? 2'b01 : (r < 7) ? 2'b10 : 2'b11;
      a = ADDR_W'($urandom % 32);
      if ($urandom % 4 != 0) begin
        if (sz == 2'b01) a[0] = 1'b0;
        if (sz == 2'b10) a[1:0] = 2'b00;
      end
      doOp(1'($urandom), 1'($urandom), a, sz, 1'($urandom), $urandom, "R9 random mix");
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule